// File: doc/BRIEF.md
# Control and Status Register Bank with Access Notify Strobes

This block is a word-wide register bank that sits behind an AXI4-Lite slave port and answers a fixed window of byte addresses. Each register slot is described by three elaboration-time attributes: who owns its contents (the bus host, internal hardware, or a module parameter), what kind of read access it grants, and what kind of write access it grants. Reads and writes may be plain, forbidden, or "notifying", in which case the bank raises a single-cycle strobe toward the hardware when the access happens.

The shipped map holds three slots. Slot 0 is a read-only identity word assembled from parameters. Slot 1 is a host-writable timeout wrap value that pulses a strobe on every accepted write. Slot 2 is a hardware-owned performance counter that the surrounding logic loads through an update port; reading it pulses a strobe so the hardware can clear its count once the bank has captured the value for the bus. Any other word inside the window reads as zero and ignores writes; anything outside the window is refused with an error response.

Top module: `csr_bank`

## Requirements
- R1: After reset, word offset 0x0 reads {MINOR_REV, MAJOR_REV, VENDOR_ID} (minor in bits 31:24, major in 23:16, vendor id 0xDEAD by default in 15:0), offset 0x4 reads 0x0000FFFF, and the timeout output equals 0x0000FFFF.
- R2: A write to offset 0x0 returns OKAY and leaves the identity word unchanged.
- R3: A write to offset 0x4 updates only the bytes whose WSTRB bit is set (bit n selects data bits 8n+7:8n); the new value is visible on the timeout output and on later reads.
- R4: The timeout write strobe is high for exactly one cycle per accepted write transaction to offset 0x4, including a write with WSTRB all zero, and never for writes elsewhere.
- R5: Offset 0x8 reads the last value loaded on the hardware update port (0 after reset), and each accepted read of 0x8 pulses the performance read strobe for exactly one cycle; writes to 0x8 return OKAY and change nothing.
- R6: Offset 0xC, inside the window but unbacked, reads zero with OKAY, and a write there returns OKAY with no effect.
- R7: Any read or write at or beyond BASE_ADDR + WINDOW_BYTES returns SLVERR (2'b10); a refused read carries zero data, and neither raises a strobe.
- R8: Write address and write data are accepted in either order and with any gap between them; BVALID rises only after both have been accepted.
- R9: At most one transaction per channel is outstanding: AWREADY and WREADY stay low while BVALID is high, ARREADY stays low while RVALID is high, and BRESP, RDATA and RRESP hold steady until the host accepts them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sAwAddr | input | ADDR_W | Write address |
| sAwValid | input | 1 | Write address valid |
| sAwReady | output | 1 | Write address ready |
| sWData | input | DATA_W | Write data |
| sWStrb | input | DATA_W/8 | Write byte strobes |
| sWValid | input | 1 | Write data valid |
| sWReady | output | 1 | Write data ready |
| sBResp | output | 2 | Write response |
| sBValid | output | 1 | Write response valid |
| sBReady | input | 1 | Write response ready |
| sArAddr | input | ADDR_W | Read address |
| sArValid | input | 1 | Read address valid |
| sArReady | output | 1 | Read address ready |
| sRData | output | DATA_W | Read data |
| sRResp | output | 2 | Read response |
| sRValid | output | 1 | Read data valid |
| sRReady | input | 1 | Read data ready |
| timeoutVal | output | DATA_W | Current timeout wrap value |
| timeoutWrPulse | output | 1 | One-cycle strobe on each accepted timeout write |
| perfLoadVal | input | DATA_W | Hardware value for the performance counter slot |
| perfLoadEn | input | 1 | Loads perfLoadVal into the performance counter slot |
| perfRdPulse | output | 1 | One-cycle strobe on each accepted performance counter read |

## Verification
The hardest situation to reach is a write whose address and data halves arrive several cycles apart, in both orders, while the response channel is also stalled; a fixed-vector walk with both halves presented together never exercises it. Directed tests therefore delay one half by a programmable number of cycles and hold BREADY or RREADY low, checking at every intermediate cycle that no response appears early and that held responses do not move. Strobe counts are accumulated over the whole vector walk and compared against the number of accesses that should have notified, which catches strobes that are lost, doubled or raised by the wrong address.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;

  typedef enum logic [1:0] {
    OWN_HOST  = 2'd0,
    OWN_HW    = 2'd1,
    OWN_PARAM = 2'd2
  } owner_e;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_PLAIN  = 2'd1,
    RD_NOTIFY = 2'd2
  } rd_access_e;

  typedef enum logic [1:0] {
    WR_NONE   = 2'd0,
    WR_PLAIN  = 2'd1,
    WR_NOTIFY = 2'd2
  } wr_access_e;

  // Strobes from the bus control to the register datapath.
  typedef struct packed {
    logic wrFire;
    logic rdFire;
  } bank_strobe_t;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  localparam int NUM_SLOTS = 3;
  localparam int SLOT_ID   = 0;
  localparam int SLOT_TMO  = 1;
  localparam int SLOT_PERF = 2;

endpackage

// File: rtl/csr_bank_slot.sv
module csr_bank_slot
  import csr_bank_pkg::*;
#(
  parameter int                DATA_W  = 32,
  parameter owner_e            OWNER   = OWN_HOST,
  parameter rd_access_e        RD_ACC  = RD_PLAIN,
  parameter wr_access_e        WR_ACC  = WR_PLAIN,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrFire,
  input  logic                wrSel,
  input  logic                rdFire,
  input  logic                rdSel,
  input  logic [DATA_W-1:0]   wData,
  input  logic [DATA_W/8-1:0] wStrb,
  input  logic [DATA_W-1:0]   hwVal,
  input  logic                hwLoad,
  output logic [DATA_W-1:0]   value,
  output logic [DATA_W-1:0]   rdWord,
  output logic                wrPulse,
  output logic                rdPulse
);

  localparam int  BYTES    = DATA_W / 8;
  localparam bit  HOST_WR  = (OWNER == OWN_HOST) && (WR_ACC != WR_NONE);
  localparam bit  READABLE = (RD_ACC != RD_NONE);

  logic hostWrite;
  assign hostWrite = wrFire && wrSel;

  generate
    if (OWNER == OWN_PARAM) begin : g_const
      assign value = RST_VAL;
    end else begin : g_store
      logic [DATA_W-1:0] store;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          store <= RST_VAL;
        end else if (OWNER == OWN_HW) begin
          if (hwLoad) store <= hwVal;
        end else if (HOST_WR && hostWrite) begin
          for (int b = 0; b < BYTES; b++) begin
            if (wStrb[b]) store[b*8 +: 8] <= wData[b*8 +: 8];
          end
        end
      end
      assign value = store;
    end
  endgenerate

  assign rdWord  = READABLE ? value : '0;
  assign wrPulse = (WR_ACC == WR_NOTIFY) && hostWrite;
  assign rdPulse = (RD_ACC == RD_NOTIFY) && rdFire && rdSel;

  logic unusedSlotInputs;
  assign unusedSlotInputs = ^{wData, wStrb, hwVal, hwLoad};

  // R4: a notify strobe never lasts two cycles
  a_r4_wr_pulse_single : assert property (@(posedge clk) disable iff (!rstN)
    wrPulse |=> !wrPulse);

  // R3: a slot moves only on a bus write to it or a hardware load
  a_r3_no_spurious_change : assert property (@(posedge clk) disable iff (!rstN)
    (!hostWrite && !hwLoad) |=> $stable(value));

endmodule

// File: rtl/csr_bank_data.sv
module csr_bank_data
  import csr_bank_pkg::*;
#(
  parameter int          DATA_W       = 32,
  parameter int          ADDR_W       = 12,
  parameter int unsigned BASE_ADDR    = 0,
  parameter int unsigned WINDOW_BYTES = 16,
  parameter logic [15:0] VENDOR_ID    = 16'hDEAD,
  parameter logic [7:0]  MAJOR_REV    = 8'h03,
  parameter logic [7:0]  MINOR_REV    = 8'h01,
  parameter logic [DATA_W-1:0] TIMEOUT_INIT = DATA_W'(32'h0000_FFFF)
) (
  input  logic                clk,
  input  logic                rstN,
  input  bank_strobe_t        strobe,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wData,
  input  logic [DATA_W/8-1:0] wStrb,
  input  logic [ADDR_W-1:0]   rdAddr,
  input  logic [DATA_W-1:0]   perfLoadVal,
  input  logic                perfLoadEn,
  output logic                wrErr,
  output logic                rdErr,
  output logic [DATA_W-1:0]   rdWord,
  output logic [DATA_W-1:0]   timeoutVal,
  output logic                timeoutWrPulse,
  output logic                perfRdPulse
);

  localparam int LSB_W = $clog2(DATA_W / 8);
  localparam int IDX_W = $clog2(WINDOW_BYTES / (DATA_W / 8));
  localparam logic [ADDR_W:0] BASE_L = (ADDR_W + 1)'(BASE_ADDR);
  localparam logic [ADDR_W:0] END_L  = (ADDR_W + 1)'(BASE_ADDR + WINDOW_BYTES);

  localparam owner_e     S_OWNER [NUM_SLOTS] = '{OWN_PARAM, OWN_HOST,  OWN_HW};
  localparam rd_access_e S_RD    [NUM_SLOTS] = '{RD_PLAIN,  RD_PLAIN,  RD_NOTIFY};
  localparam wr_access_e S_WR    [NUM_SLOTS] = '{WR_NONE,   WR_NOTIFY, WR_NONE};
  localparam logic [DATA_W-1:0] S_RST [NUM_SLOTS] = '{
    DATA_W'({MINOR_REV, MAJOR_REV, VENDOR_ID}), TIMEOUT_INIT, '0};

  function automatic logic inWindow(input logic [ADDR_W-1:0] a);
    return ({1'b0, a} >= BASE_L) && ({1'b0, a} < END_L);
  endfunction

  function automatic logic [IDX_W-1:0] wordIdx(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] off;
    off = a - BASE_L[ADDR_W-1:0];
    return off[LSB_W +: IDX_W];
  endfunction

  logic [IDX_W-1:0] wrIdx, rdIdx;
  assign wrErr = !inWindow(wrAddr);
  assign rdErr = !inWindow(rdAddr);
  assign wrIdx = wordIdx(wrAddr);
  assign rdIdx = wordIdx(rdAddr);

  logic [DATA_W-1:0] slotVal  [NUM_SLOTS];
  logic [DATA_W-1:0] slotRd   [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] slotWrP, slotRdP, slotRdSel;

  generate
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      logic wrSel, rdSel;
      assign wrSel = !wrErr && (int'(wrIdx) == i);
      assign rdSel = !rdErr && (int'(rdIdx) == i);
      assign slotRdSel[i] = rdSel;
      csr_bank_slot #(
        .DATA_W (DATA_W),
        .OWNER  (S_OWNER[i]),
        .RD_ACC (S_RD[i]),
        .WR_ACC (S_WR[i]),
        .RST_VAL(S_RST[i])
      ) u_slot (
        .clk    (clk),
        .rstN   (rstN),
        .wrFire (strobe.wrFire),
        .wrSel  (wrSel),
        .rdFire (strobe.rdFire),
        .rdSel  (rdSel),
        .wData  (wData),
        .wStrb  (wStrb),
        .hwVal  (perfLoadVal),
        .hwLoad (perfLoadEn && (i == SLOT_PERF)),
        .value  (slotVal[i]),
        .rdWord (slotRd[i]),
        .wrPulse(slotWrP[i]),
        .rdPulse(slotRdP[i])
      );
    end
  endgenerate

  always_comb begin
    rdWord = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (slotRdSel[i]) rdWord = rdWord | slotRd[i];
    end
  end

  assign timeoutVal     = slotVal[SLOT_TMO];
  assign timeoutWrPulse = slotWrP[SLOT_TMO];
  assign perfRdPulse    = slotRdP[SLOT_PERF];

  logic unusedDataSlots;
  assign unusedDataSlots = ^{slotVal[SLOT_ID], slotVal[SLOT_PERF],
                             slotWrP[SLOT_ID], slotWrP[SLOT_PERF],
                             slotRdP[SLOT_ID], slotRdP[SLOT_TMO]};

  // R2: the identity slot never changes
  a_r2_id_constant : assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $stable(slotVal[SLOT_ID]));

  // R7: at most one slot is selected for a read
  a_r7_single_select : assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(slotRdSel));

endmodule

// File: rtl/csr_bank_ctrl.sv
module csr_bank_ctrl
  import csr_bank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   sAwAddr,
  input  logic                sAwValid,
  output logic                sAwReady,
  input  logic [DATA_W-1:0]   sWData,
  input  logic [DATA_W/8-1:0] sWStrb,
  input  logic                sWValid,
  output logic                sWReady,
  output logic [1:0]          sBResp,
  output logic                sBValid,
  input  logic                sBReady,
  input  logic                sArValid,
  output logic                sArReady,
  output logic [DATA_W-1:0]   sRData,
  output logic [1:0]          sRResp,
  output logic                sRValid,
  input  logic                sRReady,
  output logic [ADDR_W-1:0]   wrAddr,
  output logic [DATA_W-1:0]   wData,
  output logic [DATA_W/8-1:0] wStrb,
  output bank_strobe_t        strobe,
  input  logic                wrErr,
  input  logic                rdErr,
  input  logic [DATA_W-1:0]   rdWord
);

  logic awHeld, wHeld;

  assign sAwReady      = !awHeld && !sBValid;
  assign sWReady       = !wHeld  && !sBValid;
  assign sArReady      = !sRValid;
  assign strobe.wrFire = awHeld && wHeld && !sBValid;
  assign strobe.rdFire = sArValid && sArReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      awHeld  <= 1'b0;
      wHeld   <= 1'b0;
      sBValid <= 1'b0;
      sBResp  <= RESP_OKAY;
      wrAddr  <= '0;
      wData   <= '0;
      wStrb   <= '0;
    end else begin
      if (sAwValid && sAwReady) begin
        awHeld <= 1'b1;
        wrAddr <= sAwAddr;
      end
      if (sWValid && sWReady) begin
        wHeld <= 1'b1;
        wData <= sWData;
        wStrb <= sWStrb;
      end
      if (strobe.wrFire) begin
        awHeld  <= 1'b0;
        wHeld   <= 1'b0;
        sBValid <= 1'b1;
        sBResp  <= wrErr ? RESP_SLVERR : RESP_OKAY;
      end else if (sBValid && sBReady) begin
        sBValid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sRValid <= 1'b0;
      sRData  <= '0;
      sRResp  <= RESP_OKAY;
    end else if (strobe.rdFire) begin
      sRValid <= 1'b1;
      sRData  <= rdErr ? '0 : rdWord;
      sRResp  <= rdErr ? RESP_SLVERR : RESP_OKAY;
    end else if (sRValid && sRReady) begin
      sRValid <= 1'b0;
    end
  end

  // R9: a pending write response blocks new write halves
  a_r9_one_write : assert property (@(posedge clk) disable iff (!rstN)
    sBValid |-> (!sAwReady && !sWReady));

  // R9: held write response stays put
  a_r9_b_hold : assert property (@(posedge clk) disable iff (!rstN)
    (sBValid && !sBReady) |=> (sBValid && $stable(sBResp)));

  // R9: held read response stays put
  a_r9_r_hold : assert property (@(posedge clk) disable iff (!rstN)
    (sRValid && !sRReady) |=> (sRValid && $stable(sRData) && $stable(sRResp)));

  // R7: refused reads carry no data
  a_r7_err_zero : assert property (@(posedge clk) disable iff (!rstN)
    (sRValid && sRResp == RESP_SLVERR) |-> (sRData == '0));

  // R8: a response is issued only when both halves were held
  a_r8_b_after_both : assert property (@(posedge clk) disable iff (!rstN)
    (!awHeld || !wHeld) && !sBValid |=> !sBValid);

endmodule

// File: rtl/csr_bank.sv
module csr_bank
  import csr_bank_pkg::*;
#(
  parameter int          DATA_W       = 32,
  parameter int          ADDR_W       = 12,
  parameter int unsigned BASE_ADDR    = 0,
  parameter int unsigned WINDOW_BYTES = 16,
  parameter logic [15:0] VENDOR_ID    = 16'hDEAD,
  parameter logic [7:0]  MAJOR_REV    = 8'h03,
  parameter logic [7:0]  MINOR_REV    = 8'h01,
  parameter logic [DATA_W-1:0] TIMEOUT_INIT = DATA_W'(32'h0000_FFFF)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   sAwAddr,
  input  logic                sAwValid,
  output logic                sAwReady,
  input  logic [DATA_W-1:0]   sWData,
  input  logic [DATA_W/8-1:0] sWStrb,
  input  logic                sWValid,
  output logic                sWReady,
  output logic [1:0]          sBResp,
  output logic                sBValid,
  input  logic                sBReady,
  input  logic [ADDR_W-1:0]   sArAddr,
  input  logic                sArValid,
  output logic                sArReady,
  output logic [DATA_W-1:0]   sRData,
  output logic [1:0]          sRResp,
  output logic                sRValid,
  input  logic                sRReady,
  output logic [DATA_W-1:0]   timeoutVal,
  output logic                timeoutWrPulse,
  input  logic [DATA_W-1:0]   perfLoadVal,
  input  logic                perfLoadEn,
  output logic                perfRdPulse
);

  bank_strobe_t        strobe;
  logic [ADDR_W-1:0]   wrAddr;
  logic [DATA_W-1:0]   wData;
  logic [DATA_W/8-1:0] wStrb;
  logic                wrErr, rdErr;
  logic [DATA_W-1:0]   rdWord;

  csr_bank_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .sAwAddr(sAwAddr), .sAwValid(sAwValid), .sAwReady(sAwReady),
    .sWData(sWData), .sWStrb(sWStrb), .sWValid(sWValid), .sWReady(sWReady),
    .sBResp(sBResp), .sBValid(sBValid), .sBReady(sBReady),
    .sArValid(sArValid), .sArReady(sArReady),
    .sRData(sRData), .sRResp(sRResp), .sRValid(sRValid), .sRReady(sRReady),
    .wrAddr(wrAddr), .wData(wData), .wStrb(wStrb), .strobe(strobe),
    .wrErr(wrErr), .rdErr(rdErr), .rdWord(rdWord)
  );

  csr_bank_data #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
    .WINDOW_BYTES(WINDOW_BYTES), .VENDOR_ID(VENDOR_ID),
    .MAJOR_REV(MAJOR_REV), .MINOR_REV(MINOR_REV), .TIMEOUT_INIT(TIMEOUT_INIT)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrAddr(wrAddr), .wData(wData), .wStrb(wStrb), .rdAddr(sArAddr),
    .perfLoadVal(perfLoadVal), .perfLoadEn(perfLoadEn),
    .wrErr(wrErr), .rdErr(rdErr), .rdWord(rdWord),
    .timeoutVal(timeoutVal), .timeoutWrPulse(timeoutWrPulse),
    .perfRdPulse(perfRdPulse)
  );

endmodule

// File: tb/csr_bank_test.sv
module csr_bank_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] sAwAddr = '0;
  logic        sAwValid = 1'b0, sAwReady;
  logic [31:0] sWData = '0;
  logic [3:0]  sWStrb = '0;
  logic        sWValid = 1'b0, sWReady;
  logic [1:0]  sBResp;
  logic        sBValid, sBReady = 1'b0;
  logic [11:0] sArAddr = '0;
  logic        sArValid = 1'b0, sArReady;
  logic [31:0] sRData;
  logic [1:0]  sRResp;
  logic        sRValid, sRReady = 1'b0;
  logic [31:0] timeoutVal;
  logic        timeoutWrPulse;
  logic [31:0] perfLoadVal = '0;
  logic        perfLoadEn = 1'b0;
  logic        perfRdPulse;

  csr_bank uut (.*);

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0, fails = 0, cycles = 0;
  int wrPulses = 0, rdPulses = 0;

  always @(posedge clk) begin
    if (rstN) begin
      if (timeoutWrPulse) wrPulses++;
      if (perfRdPulse)    rdPulses++;
    end
  end

  task automatic finishRun();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog act=%0d exp=<100000", cycles);
      finishRun();
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  bit earlyB;

  task automatic axiWrite(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s,
                          input int awDly, input int wDly, input int bDly,
                          output logic [1:0] resp);
    bit awPend = 1, wPend = 1;
    int cyc = 0;
    earlyB = 0;
    sAwAddr = a; sWData = d; sWStrb = s;
    while (awPend || wPend) begin
      bit awHs, wHs;
      @(negedge clk);
      if (sBValid) earlyB = 1;
      sAwValid = awPend && (cyc >= awDly);
      sWValid  = wPend  && (cyc >= wDly);
      awHs = sAwValid && sAwReady;
      wHs  = sWValid  && sWReady;
      @(posedge clk);
      if (awHs) awPend = 0;
      if (wHs)  wPend = 0;
      cyc++;
    end
    @(negedge clk);
    sAwValid = 0; sWValid = 0;
    while (!sBValid) @(negedge clk);
    resp = sBResp;
    for (int k = 0; k < bDly; k++) begin
      @(negedge clk);
      chk(sBValid && sBResp == resp && !sAwReady && !sWReady, "R9 b hold",
          {29'd0, sBValid, sBResp}, {29'd1, resp});
    end
    sBReady = 1;
    @(posedge clk);
    @(negedge clk);
    sBReady = 0;
  endtask

  task automatic axiRead(input logic [11:0] a, input int rDly,
                         output logic [31:0] d, output logic [1:0] resp);
    bit hs = 0;
    while (!hs) begin
      @(negedge clk);
      sArAddr = a; sArValid = 1;
      hs = sArReady;
      @(posedge clk);
    end
    @(negedge clk);
    sArValid = 0;
    while (!sRValid) @(negedge clk);
    d = sRData; resp = sRResp;
    for (int k = 0; k < rDly; k++) begin
      if (k == 0) begin perfLoadVal = 32'h5555_AAAA; perfLoadEn = 1; end
      @(negedge clk);
      perfLoadEn = 0;
      chk(sRValid && sRData == d && sRResp == resp && !sArReady, "R9 r hold", sRData, d);
    end
    sRReady = 1;
    @(posedge clk);
    @(negedge clk);
    sRReady = 0;
  endtask

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [3:0]  strb;
    logic [31:0] exp;
    logic [1:0]  resp;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 12'h000, 32'h0,          4'h0, 32'h0103_DEAD, 2'b00},  // R1
    '{1'b0, 12'h004, 32'h0,          4'h0, 32'h0000_FFFF, 2'b00},  // R1
    '{1'b1, 12'h004, 32'hA5A5_1234,  4'hF, 32'h0,         2'b00},  // R3
    '{1'b0, 12'h004, 32'h0,          4'h0, 32'hA5A5_1234, 2'b00},  // R3
    '{1'b1, 12'h004, 32'hFFFF_FF77,  4'h1, 32'h0,         2'b00},  // R3
    '{1'b0, 12'h004, 32'h0,          4'h0, 32'hA5A5_1277, 2'b00},  // R3
    '{1'b1, 12'h004, 32'h1122_3344,  4'hC, 32'h0,         2'b00},  // R3
    '{1'b0, 12'h004, 32'h0,          4'h0, 32'h1122_1277, 2'b00},  // R3
    '{1'b1, 12'h000, 32'hDEAD_BEEF,  4'hF, 32'h0,         2'b00},  // R2
    '{1'b0, 12'h000, 32'h0,          4'h0, 32'h0103_DEAD, 2'b00},  // R2
    '{1'b0, 12'h00C, 32'h0,          4'h0, 32'h0,         2'b00},  // R6
    '{1'b1, 12'h00C, 32'h0000_0001,  4'hF, 32'h0,         2'b00},  // R6
    '{1'b0, 12'h010, 32'h0,          4'h0, 32'h0,         2'b10},  // R7
    '{1'b1, 12'h010, 32'h1,          4'hF, 32'h0,         2'b10},  // R7
    '{1'b1, 12'h008, 32'h1234_5678,  4'hF, 32'h0,         2'b00},  // R5
    '{1'b0, 12'h008, 32'h0,          4'h0, 32'h0,         2'b00},  // R5
    '{1'b1, 12'h004, 32'h0,          4'h0, 32'h0,         2'b00},  // R4
    '{1'b0, 12'h004, 32'h0,          4'h0, 32'h1122_1277, 2'b00},  // R4
    '{1'b0, 12'hFFC, 32'h0,          4'h0, 32'h0,         2'b10}   // R7
  };

  initial begin
    logic [31:0] d;
    logic [1:0]  r;
    int expWr = 0, expRd = 0;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!sBValid && !sRValid, "R1 idle", {30'd0, sBValid, sRValid}, 32'd0);
    chk(timeoutVal == 32'h0000_FFFF, "R1 timeout out", timeoutVal, 32'h0000_FFFF);
    rstN = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) begin
        axiWrite(VEC[i].addr, VEC[i].data, VEC[i].strb, 0, 0, 0, r);
        chk(r == VEC[i].resp, $sformatf("R2/R3/R6/R7 wresp vec%0d", i), {30'd0, r}, {30'd0, VEC[i].resp});
        if (VEC[i].addr == 12'h004) expWr++;
      end else begin
        axiRead(VEC[i].addr, 0, d, r);
        chk(d == VEC[i].exp && r == VEC[i].resp, $sformatf("R1/R3/R5/R6/R7 read vec%0d", i), d, VEC[i].exp);
        if (VEC[i].addr == 12'h008) expRd++;
      end
    end
    // R4 and R5: strobe counts across the walk
    chk(wrPulses == expWr, "R4 write strobes", wrPulses, expWr);
    chk(rdPulses == expRd, "R5 read strobes", rdPulses, expRd);
    chk(timeoutVal == 32'h1122_1277, "R3 timeout out", timeoutVal, 32'h1122_1277);

    // R8: data first, address three cycles later, no early response
    axiWrite(12'h004, 32'hCAFE_0001, 4'hF, 3, 0, 0, r);
    chk(!earlyB && r == 2'b00, "R8 w-first", {31'd0, earlyB}, 32'd0);
    chk(timeoutVal == 32'hCAFE_0001, "R8 w-first value", timeoutVal, 32'hCAFE_0001);
    // R8: address first, data three cycles later; R9 response stall
    axiWrite(12'h004, 32'hCAFE_0002, 4'hF, 0, 3, 3, r);
    chk(!earlyB && r == 2'b00, "R8 aw-first", {31'd0, earlyB}, 32'd0);
    chk(timeoutVal == 32'hCAFE_0002, "R8 aw-first value", timeoutVal, 32'hCAFE_0002);
    chk(wrPulses == expWr + 2, "R4 strobe per transaction", wrPulses, expWr + 2);

    // R5: hardware load, then read; held read not disturbed by a later load (R9)
    @(negedge clk);
    perfLoadVal = 32'h0BAD_F00D; perfLoadEn = 1;
    @(negedge clk);
    perfLoadEn = 0;
    axiRead(12'h008, 3, d, r);
    chk(d == 32'h0BAD_F00D && r == 2'b00, "R5 perf value", d, 32'h0BAD_F00D);
    chk(rdPulses == expRd + 1, "R5 one read strobe", rdPulses, expRd + 1);
    axiRead(12'h008, 0, d, r);
    chk(d == 32'h5555_AAAA, "R5 reload", d, 32'h5555_AAAA);
    // R7: refused write raises no strobe and changes nothing
    axiWrite(12'h014, 32'h0, 4'hF, 0, 0, 0, r);
    chk(r == 2'b10 && timeoutVal == 32'hCAFE_0002, "R7 refused write", {30'd0, r}, 32'd2);
    chk(wrPulses == expWr + 2, "R7 no strobe", wrPulses, expWr + 2);

    finishRun();
  end

endmodule